// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits at the front of instruction decode in a 64-bit RISC-V style core. Each cycle it may accept one instruction parcel. When the two low bits of the parcel mark a 16-bit compressed form, it rebuilds the one 32-bit base instruction that does the same work. When they mark a full-length instruction, it forwards the parcel untouched. The stage after it therefore only ever sees full-length encodings, so compressed and native instructions share one execution path.

The expander covers an integer subset:
- add immediate, add immediate word, load immediate and load upper immediate;
- shift left immediate;
- register move and register add;
- branch on zero and branch on non-zero;
- word and doubleword loads and stores relative to the stack pointer.

It remaps the 3-bit register fields of the compact forms into the x8..x15 window. It reassembles every immediate into the bit positions of the target format. A reserved or unsupported encoding raises an illegal flag, and the expanded word is then meaningless. The result is registered, so it appears one clock after the parcel is presented.

There are no control states. The only sequential element is the output register, which moves from reset to capture on the first valid parcel.

Top module: `cexp_expander`

## Requirements
- R1: A parcel presented with `in_valid` high produces `out_valid` high on the following clock edge. A cycle with `in_valid` low yields `out_valid` low one edge later.
- R2: A parcel whose bits [1:0] equal 11 is forwarded unchanged, with `out_compressed` and `out_illegal` both low. Every legal expanded output has bits [1:0] equal to 11.
- R3: Branch on zero (quadrant 01, funct3 110) and branch on non-zero (funct3 111) expand to a branch that compares against x0, with funct3 000 and 001 respectively. The register is x8 plus the 3-bit field in bits [9:7]. The 9-bit even offset is taken from bits 12, 6:5, 2, 11:10 and 4:3, from offset bit 8 down to offset bit 1, and is sign-extended.
- R4: Quadrant 01 funct3 000 expands to an add immediate of rd to itself, and funct3 010 to an add immediate into rd from x0. rd sits in bits [11:7], and the immediate is bit 12 followed by bits [6:2], sign-extended (-32..+31).
- R5: Quadrant 01 funct3 001 expands to add immediate word (opcode 0011011) on rd with the same immediate. An rd of zero is illegal.
- R6: Quadrant 01 funct3 011 expands to load upper immediate, with the 6-bit signed value placed in the upper field (scaled by 4096). An rd of 0 or 2, or a zero value, is illegal.
- R7: Quadrant 10 funct3 000 expands to shift left immediate of rd by the 6-bit amount formed from bit 12 and bits [6:2].
- R8: Quadrant 10 funct3 010 and 011 expand to word and doubleword loads from x2. Their zero-extended offsets are scaled by 4 and by 8. An rd of zero is illegal.
- R9: Quadrant 10 funct3 110 and 111 expand to word and doubleword stores to x2. The source register is in bits [6:2], and the offsets are zero-extended and scaled by 4 and by 8.
- R10: Quadrant 10 funct3 100 with a non-zero bits [6:2] expands to a register add. When bit 12 is 0 this is a move (add rd = x0 + rs2). When bit 12 is 1 it is a true add (add rd = rd + rs2). Both forms reach all 32 registers.
- R11: Quadrant 00 (including the all-zero parcel), quadrant 01 funct3 100 and 101, quadrant 10 funct3 001 and 101, and quadrant 10 funct3 100 with bits [6:2] zero all raise `out_illegal`.
- R12: While reset is asserted, `out_valid`, `out_instr`, `out_compressed` and `out_illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parcel present this cycle |
| in_parcel | input | 32 | Parcel. Bits [15:0] hold a compressed form; all 32 bits hold a native instruction |
| out_valid | output | 1 | Expanded result valid |
| out_instr | output | 32 | Full-length instruction |
| out_compressed | output | 1 | Result came from a 16-bit form |
| out_illegal | output | 1 | Reserved or unsupported compressed encoding |

## Verification
Two functions can meet in the output register on adjacent cycles. An expansion can be replaced by a forwarded native word, and an illegal reserved parcel can be followed at once by a legal one. The bench feeds parcels back to back with no idle cycles. It draws random mixes of the three compressed quadrants and of full-length words, so each result has to overwrite a result of the other kind. Each output is judged one cycle after its parcel against a bench-side expander, including the fall of the illegal flag.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
    localparam int ILEN = 32;
    localparam int CLEN = 16;
    localparam int RW   = 5;
    localparam int CRW  = 3;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_IMM32  = 7'b0011011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_UPPER  = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    localparam logic [RW-1:0] REG_ZERO = 5'd0;
    localparam logic [RW-1:0] REG_SP   = 5'd2;

    // compact 3-bit field selects x8..x15
    function automatic logic [RW-1:0] win_reg(input logic [CRW-1:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic [ILEN-1:0] fmt_i(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                              input logic [2:0] f3, input logic [RW-1:0] rd,
                                              input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [ILEN-1:0] fmt_s(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                              input logic [RW-1:0] rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
    endfunction

    function automatic logic [ILEN-1:0] fmt_b(input logic [12:0] off, input logic [RW-1:0] rs1,
                                              input logic [2:0] f3);
        return {off[12], off[10:5], REG_ZERO, rs1, f3, off[4:1], off[11], OPC_BRANCH};
    endfunction

    function automatic logic [ILEN-1:0] fmt_u(input logic [19:0] imm, input logic [RW-1:0] rd);
        return {imm, rd, OPC_UPPER};
    endfunction

    function automatic logic [ILEN-1:0] fmt_r(input logic [RW-1:0] rs2, input logic [RW-1:0] rs1,
                                              input logic [RW-1:0] rd);
        return {7'b0000000, rs2, rs1, 3'b000, rd, OPC_REG};
    endfunction
endpackage

// File: rtl/cexp_quad1.sv
module cexp_quad1
    import cexp_pkg::*;
(
    input  logic [CLEN-1:2] c,
    output logic [ILEN-1:0] x,
    output logic            bad
);
    logic [RW-1:0] rd;
    logic [5:0]    imm6;
    logic [11:0]   simm;
    logic [12:0]   boff;

    assign rd   = c[11:7];
    assign imm6 = {c[12], c[6:2]};
    assign simm = {{6{c[12]}}, imm6};
    assign boff = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};

    always_comb begin
        x   = '0;
        bad = 1'b0;
        unique case (c[15:13])
            3'b000: x = fmt_i(simm, rd, 3'b000, rd, OPC_IMM);
            3'b001: begin
                x   = fmt_i(simm, rd, 3'b000, rd, OPC_IMM32);
                bad = (rd == REG_ZERO);
            end
            3'b010: x = fmt_i(simm, REG_ZERO, 3'b000, rd, OPC_IMM);
            3'b011: begin
                x   = fmt_u({{14{c[12]}}, imm6}, rd);
                bad = (rd == REG_ZERO) || (rd == REG_SP) || (imm6 == 6'd0);
            end
            3'b110: x = fmt_b(boff, win_reg(c[9:7]), 3'b000);
            3'b111: x = fmt_b(boff, win_reg(c[9:7]), 3'b001);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/cexp_quad2.sv
module cexp_quad2
    import cexp_pkg::*;
(
    input  logic [CLEN-1:2] c,
    output logic [ILEN-1:0] x,
    output logic            bad
);
    logic [RW-1:0] rd;
    logic [RW-1:0] rs2;
    logic [11:0]   off_lw, off_ld, off_sw, off_sd;

    assign rd     = c[11:7];
    assign rs2    = c[6:2];
    assign off_lw = {4'b0, c[3:2], c[12], c[6:4], 2'b0};
    assign off_ld = {3'b0, c[4:2], c[12], c[6:5], 3'b0};
    assign off_sw = {4'b0, c[8:7], c[12:9], 2'b0};
    assign off_sd = {3'b0, c[9:7], c[12:10], 3'b0};

    always_comb begin
        x   = '0;
        bad = 1'b0;
        unique case (c[15:13])
            3'b000: x = fmt_i({6'b0, c[12], c[6:2]}, rd, 3'b001, rd, OPC_IMM);
            3'b010: begin
                x   = fmt_i(off_lw, REG_SP, 3'b010, rd, OPC_LOAD);
                bad = (rd == REG_ZERO);
            end
            3'b011: begin
                x   = fmt_i(off_ld, REG_SP, 3'b011, rd, OPC_LOAD);
                bad = (rd == REG_ZERO);
            end
            3'b100: begin
                x   = fmt_r(rs2, c[12] ? rd : REG_ZERO, rd);
                bad = (rs2 == REG_ZERO);
            end
            3'b110: x = fmt_s(off_sw, rs2, REG_SP, 3'b010);
            3'b111: x = fmt_s(off_sd, rs2, REG_SP, 3'b011);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
    import cexp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ILEN-1:0] in_parcel,
    output logic            out_valid,
    output logic [ILEN-1:0] out_instr,
    output logic            out_compressed,
    output logic            out_illegal
);
    logic [ILEN-1:0] q1_x, q2_x, nx_instr;
    logic            q1_bad, q2_bad, nx_bad, nx_comp;

    cexp_quad1 u_q1 (.c(in_parcel[CLEN-1:2]), .x(q1_x), .bad(q1_bad));
    cexp_quad2 u_q2 (.c(in_parcel[CLEN-1:2]), .x(q2_x), .bad(q2_bad));

    always_comb begin
        nx_comp = (in_parcel[1:0] != 2'b11);
        unique case (in_parcel[1:0])
            2'b00: begin nx_instr = '0;        nx_bad = 1'b1;   end
            2'b01: begin nx_instr = q1_x;      nx_bad = q1_bad; end
            2'b10: begin nx_instr = q2_x;      nx_bad = q2_bad; end
            default: begin nx_instr = in_parcel; nx_bad = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_instr      <= '0;
            out_compressed <= 1'b0;
            out_illegal    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_instr      <= nx_instr;
                out_compressed <= nx_comp;
                out_illegal    <= nx_bad;
            end
        end
    end

    p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_parcel[1:0] == 2'b11) |=>
            (out_instr == $past(in_parcel) && !out_compressed && !out_illegal));
    p_full_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |-> (out_instr[1:0] == 2'b11));
    p_brwin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_compressed && !out_illegal && out_instr[6:0] == OPC_BRANCH) |->
            (out_instr[19:18] == 2'b01 && out_instr[24:20] == 5'd0));
    p_q0_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_parcel[1:0] == 2'b00) |=> out_illegal);
endmodule

// File: tb/cexp_expander_tb.sv
module cexp_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_parcel = '0;
    logic        out_valid, out_compressed, out_illegal;
    logic [31:0] out_instr;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    cexp_expander u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_parcel(in_parcel),
        .out_valid(out_valid), .out_instr(out_instr),
        .out_compressed(out_compressed), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
    endfunction
    function automatic logic [31:0] e_s(int imm, int rs2, int f3);
        logic [31:0] v = imm;
        return {v[11:5], 5'(rs2), 5'd2, 3'(f3), v[4:0], 7'b0100011};
    endfunction

    // bench-side expander built from the requirement text
    task automatic model(input logic [15:0] c, output bit bad, output logic [31:0] x,
                         output string tag);
        int rd = c[11:7];
        int r2 = c[6:2];
        int si = $signed({c[12], c[6:2]});
        int ui = {c[12], c[6:2]};
        int f  = c[15:13];
        bad = 0; x = '0; tag = "R11";
        if (c[1:0] == 2'b01) begin
            case (f)
                0: begin tag = "R4"; x = e_i(si, rd, 0, rd, 7'b0010011); end
                1: begin tag = "R5"; bad = (rd == 0); x = e_i(si, rd, 0, rd, 7'b0011011); end
                2: begin tag = "R4"; x = e_i(si, 0, 0, rd, 7'b0010011); end
                3: begin
                    logic [31:0] u = si * 4096;
                    tag = "R6"; bad = (rd == 0 || rd == 2 || ui == 0);
                    x = {u[31:12], 5'(rd), 7'b0110111};
                end
                6, 7: begin
                    int off = $signed({c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0});
                    logic [31:0] o = off;
                    tag = "R3";
                    x = {o[12], o[10:5], 5'd0, 5'(8 + c[9:7]), (f == 7) ? 3'b001 : 3'b000,
                         o[4:1], o[11], 7'b1100011};
                end
                default: bad = 1;
            endcase
        end else if (c[1:0] == 2'b10) begin
            case (f)
                0: begin tag = "R7"; x = e_i(ui, rd, 1, rd, 7'b0010011); end
                2: begin tag = "R8"; bad = (rd == 0);
                    x = e_i(4 * {c[3:2], c[12], c[6:4]}, 2, 2, rd, 7'b0000011); end
                3: begin tag = "R8"; bad = (rd == 0);
                    x = e_i(8 * {c[4:2], c[12], c[6:5]}, 2, 3, rd, 7'b0000011); end
                4: begin
                    if (r2 == 0) bad = 1;
                    else begin
                        tag = "R10";
                        x = {7'd0, 5'(r2), c[12] ? 5'(rd) : 5'd0, 3'd0, 5'(rd), 7'b0110011};
                    end
                end
                6: begin tag = "R9"; x = e_s(4 * {c[8:7], c[12:9]}, r2, 2); end
                7: begin tag = "R9"; x = e_s(8 * {c[9:7], c[12:10]}, r2, 3); end
                default: bad = 1;
            endcase
        end else bad = 1;
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p);
        bit bad; logic [31:0] x; string tag;
        in_valid = 1'b1; in_parcel = p;
        @(posedge clk); @(negedge clk);
        if (p[1:0] == 2'b11) begin
            check(out_valid && out_instr == p && !out_compressed && !out_illegal,
                  "R2", out_instr, p);
        end else begin
            model(p[15:0], bad, x, tag);
            if (bad)
                check(out_valid && out_illegal && out_compressed, tag,
                      {31'd0, out_illegal}, 32'd1);
            else
                check(out_valid && !out_illegal && out_compressed && out_instr == x,
                      tag, out_instr, x);
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!out_valid && out_instr == 0 && !out_compressed && !out_illegal, "R12",
              out_instr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: load immediate x10 <- -1
        in_valid = 1'b1; in_parcel = 32'h0000_557D;
        @(posedge clk); @(negedge clk);
        check(out_instr == 32'hFFF0_0513 && !out_illegal, "R4", out_instr, 32'hFFF0_0513);
        apply(32'h0000_0000);            // R11 all-zero parcel
        apply(32'h0000_557D);            // R4 right after an illegal one
        apply(32'h0000_6405);            // R6 rd=8 value 1
        apply(32'h0000_6105);            // R6 rd=2 is illegal
        apply(32'h0000_C001);            // R3 branch on zero, x8, offset 0
        apply(32'h0000_FFFD);            // R3 branch on non-zero, negative offset
        apply(32'h0000_8002);            // R11 register field zero
        apply(32'h0000_9F86);            // R10 add x31 += x1
        apply(32'h0000_5082);            // R8 word load
        apply(32'h0000_E286);            // R9 doubleword store
        apply(32'h0000_1FFE);            // R7 shift by 63, rd=31
        apply(32'h0000_2001);            // R5 rd=0 illegal
        // R1 idle cycle
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!out_valid, "R1", {31'd0, out_valid}, 32'd0);
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            if (r[1:0] == 2'b11 && i[0]) r[1:0] = 2'(i % 3);
            apply(r);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule